// File: doc/BRIEF.md
# CAN Received-Bit Majority Voter

This block settles the logic value of each received CAN bit from the synchronized receive line. A short history of the line level is captured once per time quantum. When the bit-timing logic flags the sample point, the block either takes the newest sample as the bit (single mode) or votes across the newest three samples (triple mode). Triple mode filters out a one-quantum disturbance that lands on the sample point.

The sampling mode is held in a one-bit configuration register, which can be changed only while the controller is frozen. Triple mode takes effect only if phase segment 1 is at least two quanta long and flexible-data-rate operation is off. If triple mode is requested with too short a segment, a configuration-error flag is raised and the block samples once. With flexible data rate on, the request is ignored without error. The decided bit and a one-cycle valid strobe appear one clock after the sample-point strobe.

Top module: `can_bit_voter`

## Requirements
- R1: In single mode the decided bit equals the newest captured sample of the receive line.
- R2: In triple mode the decided bit is the majority of the newest three captured samples, so a single differing sample among them cannot change the result.
- R3: A sample is captured on every quantum tick. If a tick and the sample-point strobe fall in the same cycle, the receive level of that cycle counts as the newest sample. A strobe without a tick uses the three samples already captured.
- R4: With triple mode requested, flexible data rate off and phase segment 1 below 2 quanta, cfg_err is 1 and the block samples once as in R1. At 2 quanta or more, cfg_err is 0 and triple voting applies.
- R5: While fd_en is 1 a triple-mode request is ignored: the block samples once and cfg_err stays 0.
- R6: A mode write (mode_wr with mode_wdata, 1 = triple) takes effect only while freeze is 1. Outside freeze the stored mode is unchanged.
- R7: bit_valid is 1 for exactly one cycle, the cycle after each sample-point strobe. bit_out changes only at that point and holds otherwise.
- R8: After reset bit_valid is 0, bit_out is 1 (recessive), cfg_err is 0, single mode is selected and the sample history holds recessive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sync | input | 1 | Synchronized receive line level |
| tq_tick | input | 1 | One-cycle pulse per time quantum |
| sp_strobe | input | 1 | One-cycle pulse at the sample point |
| pseg1_len | input | PSEG_W | Phase segment 1 length in quanta |
| mode_wr | input | 1 | Sampling-mode write strobe |
| mode_wdata | input | 1 | Mode value to write (1 = triple) |
| fd_en | input | 1 | Flexible-data-rate operation enabled |
| freeze | input | 1 | Controller in freeze mode |
| bit_out | output | 1 | Decided bit value |
| bit_valid | output | 1 | One-cycle strobe for a new bit_out |
| cfg_err | output | 1 | Triple mode requested with too short a phase segment 1 |

## Verification
History capture and the vote can occur in the same cycle when a quantum tick coincides with the sample-point strobe. The vote must then see the level that is being captured in that cycle. The bench provokes this by raising the tick and the strobe together on the third sample of every pattern. It also runs one pattern where the strobe arrives alone after three ticks. It judges both against a majority it computes by summing the three driven levels. Placing glitches at and just before the sample point shows whether the coincident sample was used.

// File: rtl/can_bit_voter_pkg.sv
package can_bit_voter_pkg;
  localparam int unsigned VOTE_SAMPLES = 3;
  localparam int unsigned MIN_PSEG_TRIPLE = 2;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic pseg_allows_triple(input int unsigned len);
    return len >= MIN_PSEG_TRIPLE;
  endfunction
endpackage

// File: rtl/cbv_history.sv
module cbv_history #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             rx_sync,
  output logic [DEPTH-1:0] hist,
  output logic [DEPTH-1:0] window
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = rx_sync;
    end else begin : g_tail
      assign nxt = hist[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist[i] <= 1'b1;
      else if (tq_tick) hist[i] <= nxt;
    end
    assign window[i] = tq_tick ? nxt : hist[i];
  end
endmodule

// File: rtl/cbv_mode_ctrl.sv
module cbv_mode_ctrl #(
  parameter int unsigned PSEG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_wdata,
  input  logic              freeze,
  input  logic              fd_en,
  input  logic [PSEG_W-1:0] pseg1_len,
  output logic              mode_q,
  output logic              triple_act,
  output logic              cfg_err
);
  import can_bit_voter_pkg::*;

  logic wr_ok, triple_req, pseg_ok;

  assign wr_ok = mode_wr & freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= 1'b0;
    else if (wr_ok) mode_q <= mode_wdata;
  end

  assign triple_req = mode_q & ~fd_en;
  assign pseg_ok    = pseg_allows_triple(int'(pseg1_len));
  assign triple_act = triple_req & pseg_ok;
  assign cfg_err    = triple_req & ~pseg_ok;
endmodule

// File: rtl/cbv_decider.sv
module cbv_decider #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sp_strobe,
  input  logic             triple_act,
  input  logic [DEPTH-1:0] window,
  output logic             vote,
  output logic             bit_out,
  output logic             bit_valid
);
  import can_bit_voter_pkg::*;

  assign vote = triple_act ? maj3(window[2:0]) : window[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b1;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= sp_strobe;
      if (sp_strobe) bit_out <= vote;
    end
  end
endmodule

// File: rtl/can_bit_voter.sv
module can_bit_voter #(
  parameter int unsigned PSEG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sync,
  input  logic              tq_tick,
  input  logic              sp_strobe,
  input  logic [PSEG_W-1:0] pseg1_len,
  input  logic              mode_wr,
  input  logic              mode_wdata,
  input  logic              fd_en,
  input  logic              freeze,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              cfg_err
);
  import can_bit_voter_pkg::*;
  localparam int unsigned DEPTH = VOTE_SAMPLES;

  logic [DEPTH-1:0] hist, window;
  logic mode_q, triple_act, vote;

  cbv_history #(.DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_sync(rx_sync),
    .hist(hist), .window(window)
  );

  cbv_mode_ctrl #(.PSEG_W(PSEG_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .freeze(freeze), .fd_en(fd_en), .pseg1_len(pseg1_len),
    .mode_q(mode_q), .triple_act(triple_act), .cfg_err(cfg_err)
  );

  cbv_decider #(.DEPTH(DEPTH)) u_dec (
    .clk(clk), .rst_n(rst_n), .sp_strobe(sp_strobe), .triple_act(triple_act),
    .window(window), .vote(vote), .bit_out(bit_out), .bit_valid(bit_valid)
  );
endmodule

// File: rtl/can_bit_voter_checker.sv
module can_bit_voter_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sp_strobe,
  input logic       mode_wr,
  input logic       freeze,
  input logic       fd_en,
  input logic       mode_q,
  input logic       triple_act,
  input logic       vote,
  input logic [2:0] window,
  input logic       bit_out,
  input logic       bit_valid,
  input logic       cfg_err
);
  assert_valid_after_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_strobe |=> bit_valid);
  assert_no_valid_without_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_strobe |=> !bit_valid);
  assert_bit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_strobe |=> $stable(bit_out));
  assert_fd_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fd_en |-> (!cfg_err && !triple_act));
  assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!triple_act && vote == window[0]));
  assert_write_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !freeze) |=> $stable(mode_q));
  assert_vote_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_strobe |=> bit_out == $past(vote));
endmodule

bind can_bit_voter can_bit_voter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sp_strobe(sp_strobe), .mode_wr(mode_wr),
  .freeze(freeze), .fd_en(fd_en), .mode_q(mode_q), .triple_act(triple_act),
  .vote(vote), .window(window), .bit_out(bit_out), .bit_valid(bit_valid),
  .cfg_err(cfg_err)
);

// File: tb/tb_can_bit_voter.sv
module tb_can_bit_voter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sync = 1'b1, tq_tick = 1'b0, sp_strobe = 1'b0;
  logic [2:0] pseg1_len = 3'd3;
  logic mode_wr = 1'b0, mode_wdata = 1'b0, fd_en = 1'b0, freeze = 1'b0;
  logic bit_out, bit_valid, cfg_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_bit_voter dut (
    .clk(clk), .rst_n(rst_n), .rx_sync(rx_sync), .tq_tick(tq_tick),
    .sp_strobe(sp_strobe), .pseg1_len(pseg1_len), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .fd_en(fd_en), .freeze(freeze),
    .bit_out(bit_out), .bit_valid(bit_valid), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic quantum(input logic v, input logic sp);
    @(negedge clk);
    rx_sync = v; tq_tick = 1'b1; sp_strobe = sp;
    @(negedge clk);
    tq_tick = 1'b0; sp_strobe = 1'b0;
  endtask

  task automatic write_mode(input logic v, input logic frz);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = v; freeze = frz;
    @(negedge clk);
    mode_wr = 1'b0; freeze = 1'b0;
  endtask

  // three quanta, strobe together with the last tick (R3 coincidence)
  task automatic pattern(input string req, input logic a, input logic b,
                         input logic c, input logic triple);
    logic exp;
    exp = triple ? ((int'(a) + int'(b) + int'(c)) >= 2) : c;
    quantum(a, 1'b0);
    quantum(b, 1'b0);
    quantum(c, 1'b1);
    chk({req, " valid"}, bit_valid, 1'b1);
    chk({req, " bit"}, bit_out, exp);
    @(negedge clk);
    chk({req, " R7 one-cycle valid"}, bit_valid, 1'b0);
    chk({req, " R7 hold"}, bit_out, exp);
  endtask

  task automatic t_reset;
    chk("R8 valid", bit_valid, 1'b0);
    chk("R8 bit", bit_out, 1'b1);
    chk("R8 cfg_err", cfg_err, 1'b0);
    // strobe alone right after reset: history is recessive
    @(negedge clk); sp_strobe = 1'b1;
    @(negedge clk); sp_strobe = 1'b0;
    chk("R8 history recessive", bit_out, 1'b1);
  endtask

  task automatic t_single;
    pattern("R1 glitch at sp", 1'b0, 1'b0, 1'b1, 1'b0);
    pattern("R1 glitch before sp", 1'b1, 1'b0, 1'b1, 1'b0);
    pattern("R1 steady dominant", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_triple;
    write_mode(1'b1, 1'b1);
    chk("R4 no err pseg3", cfg_err, 1'b0);
    pattern("R2 glitch at sp suppressed", 1'b0, 1'b0, 1'b1, 1'b1);
    pattern("R2 glitch before sp suppressed", 1'b1, 1'b0, 1'b1, 1'b1);
    pattern("R2 oldest differs", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_separate_sp;
    quantum(1'b0, 1'b0);
    quantum(1'b1, 1'b0);
    quantum(1'b1, 1'b0);
    @(negedge clk); rx_sync = 1'b0; sp_strobe = 1'b1;
    @(negedge clk); sp_strobe = 1'b0;
    chk("R3 strobe without tick valid", bit_valid, 1'b1);
    chk("R3 strobe without tick uses stored", bit_out, 1'b1);
  endtask

  task automatic t_freeze_block;
    write_mode(1'b0, 1'b0);
    pattern("R6 blocked write keeps triple", 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_pseg;
    pseg1_len = 3'd1;
    @(negedge clk);
    chk("R4 err pseg1", cfg_err, 1'b1);
    pattern("R4 fallback single", 1'b0, 1'b0, 1'b1, 1'b0);
    pseg1_len = 3'd2;
    @(negedge clk);
    chk("R4 no err pseg2", cfg_err, 1'b0);
    pattern("R4 triple at pseg2", 1'b0, 1'b0, 1'b1, 1'b1);
    pseg1_len = 3'd3;
  endtask

  task automatic t_fd;
    fd_en = 1'b1; pseg1_len = 3'd1;
    @(negedge clk);
    chk("R5 no err with fd", cfg_err, 1'b0);
    pseg1_len = 3'd3;
    pattern("R5 fd forces single", 1'b0, 1'b0, 1'b1, 1'b0);
    fd_en = 1'b0;
  endtask

  task automatic t_clear;
    write_mode(1'b0, 1'b1);
    pattern("R6 frozen write clears", 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_triple();
    t_separate_sp();
    t_freeze_block();
    t_pseg();
    t_fd();
    t_clear();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule